// File: doc/BRIEF.md
# Wide Register Collector Bus Interface

This block is the slave end of a 32-bit memory-mapped host port in front of a bank of 128-bit control registers, a small store of 64-bit entries and a few doorbell registers. The host can only move one dword per request, so a wide register is updated by a run of dword writes. The block keeps the lower dwords in a staging buffer and changes the target register only when the top dword arrives. The whole value then lands in one clock edge, and internal logic never sees half of an update.

Reads work the other way round. Reading the lowest dword of a wide register captures all 128 bits in a shadow buffer, and the upper dwords are then served from that copy. The four dwords a host reads therefore always come from one point in time. The 64-bit entries follow the same scheme with two dwords. Three doorbell registers in every page (an event-queue read pointer, a receive descriptor doorbell and a transmit descriptor doorbell) take a single dword write at once. They can be written in the middle of a staged sequence without harming it.

The address space is split into pages of 0x2000 bytes. Each page holds its own wide registers and doorbells. The entry store lives in the upper half of the address space.

Top module: `wide_reg_collector`

## Requirements
- R1: Wide register n of page p is at byte address p*0x2000 + n*16 for n below NUM_WIDE. Dword k of it (k = 0..3) is at offset 4*k within that slot, and dword k carries bits 32k+31..32k. Address bits 1:0 are ignored.
- R2: A write to dword 0, 1 or 2 of a wide register changes only the staging buffer. A dword-0 read of that register still returns its previous value.
- R3: A write to dword 3 whose slot matches the staged slot replaces all 128 bits of the register in one cycle: bits 127:96 from the write and the lower bits from the staged dwords.
- R4: The staging buffer holds the slot of the first dword written after it was last emptied. A dword-3 write to a different slot, or with nothing staged, leaves every register unchanged and sets seq_err. The buffer is emptied after any dword-3 write.
- R5: A dword-0 read returns dword 0 of the live register and copies all 128 bits into the shadow. Later reads of dwords 1 to 3 return the shadow, even if the register has been written since.
- R6: A read of dword 1, 2 or 3 with no earlier dword-0 read of that slot returns whatever the shadow holds. After reset the shadow holds zero.
- R7: Doorbell k of page p (k = 0 event-queue pointer, 1 receive, 2 transmit) sits at p*0x2000 + 0x1000 + 16*k. A write stores the dword and, one cycle later, raises db_stb for one cycle with db_page = p, db_sel = k and db_val = the data. A read returns the stored value. Doorbell writes leave a partly staged wide write intact.
- R8: Entry i of the 64-bit store is at 0x8000 + 8*i. A write to offset 0 stages the low half, and a write to offset 4 of the same entry commits both halves. A mismatch sets seq_err in the same way as R4. A read at offset 0 returns the low half and captures the high half, and a read at offset 4 returns that captured half.
- R9: Registers and doorbells in different pages are separate. A write in one page never changes another page.
- R10: Every accepted read produces rsp_vld with rsp_data exactly one cycle later. No other cycle raises rsp_vld. Addresses that hit nothing read as zero and ignore writes. req_rdy is always high.
- R11: Reset clears the wide registers, the entry store, the doorbells, both staging buffers, both shadows and seq_err. Once set, seq_err stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld | input | 1 | Host request valid |
| req_rdy | output | 1 | Request accepted (always high) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_vld | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| db_stb | output | 1 | One-cycle pulse after a doorbell write |
| db_page | output | PG_W | Page of the doorbell written |
| db_sel | output | 2 | Which doorbell: 0 event pointer, 1 receive, 2 transmit |
| db_val | output | 32 | Value written to the doorbell |
| seq_err | output | 1 | Sticky flag for a commit that was dropped |

## Verification
The bench interleaves staged sequences with reads of the same slot. A design that committed early would then show new data on a dword-0 read before dword 3 was written. It also writes a register between a dword-0 read and the upper-dword reads, which catches a design that serves the upper dwords from the live register. A doorbell write is placed in the middle of a staged sequence, and a design whose doorbell path clears or overwrites the staging buffer then commits the wrong value. Mismatched final dwords, final dwords with nothing staged, cross-page writes and reads of never-snapshotted slots check that the drop, sticky-error, page-isolation and stale-shadow rules are followed rather than quietly repaired.

// File: rtl/wrc_pkg.sv
// Shared definitions for the wide register collector.
// Assumes nothing beyond a single clock domain.
package wrc_pkg;

    // Which storage a host address lands in.
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_WIDE  = 2'd1,
        TGT_DBELL = 2'd2,
        TGT_SRAM  = 2'd3
    } wrc_tgt_e;

    localparam int DWORD_W    = 32;
    localparam int WIDE_LANES = 4;
    localparam int SRAM_LANES = 2;
    localparam int DB_PER_PG  = 3;
    localparam int PAGE_SHIFT = 13;   // 0x2000-byte page blocks

endpackage

// File: rtl/wrc_decode.sv
// Address decoder: splits a byte address into target, page, slot, lane,
// entry index and doorbell number.
// Assumes: pages of 2**PAGE_SHIFT bytes, wide slots at a 16-byte stride from
// page offset 0, doorbells at a 16-byte stride from page offset 0x1000, the
// entry store selected by the top address bit, and power-of-two counts.
module wrc_decode
    import wrc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_WIDE   = 4,
    parameter int SRAM_DEPTH = 16,
    parameter int PG_W       = 2,
    parameter int SL_W       = 2,
    parameter int SR_W       = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output wrc_tgt_e          tgt,
    output logic [PG_W-1:0]   page,
    output logic [SL_W-1:0]   slot,
    output logic [1:0]        lane,
    output logic [SR_W-1:0]   sram_idx,
    output logic [1:0]        db_sel
);
    localparam int ROW_W = PAGE_SHIFT - 4;
    localparam int UP_W  = ADDR_W - 4;
    localparam logic [ROW_W-1:0] WIDE_ROWS = ROW_W'(NUM_WIDE);
    localparam logic [ROW_W-1:0] DB_ROW0   = ROW_W'(12'h100);
    localparam logic [ROW_W-1:0] DB_ROWEND = ROW_W'(12'h100 + DB_PER_PG);
    localparam logic [UP_W-1:0]  SR_LIM    = UP_W'(SRAM_DEPTH);

    logic [ROW_W-1:0] row;
    logic [UP_W-1:0]  sram_row;
    logic             sram_sel;
    logic             unused_bits;

    assign row         = addr[PAGE_SHIFT-1:4];
    assign sram_row    = addr[ADDR_W-2:3];
    assign sram_sel    = addr[ADDR_W-1];
    assign unused_bits = ^addr[1:0];

    assign page     = addr[PAGE_SHIFT +: PG_W];
    assign slot     = row[SL_W-1:0];
    assign lane     = addr[3:2];
    assign sram_idx = addr[3 +: SR_W];
    assign db_sel   = row[1:0];

    // Pick the target region from the address bits.
    always_comb begin
        tgt = TGT_NONE;
        if (sram_sel) begin
            if (sram_row < SR_LIM) tgt = TGT_SRAM;
        end else if (row < WIDE_ROWS) begin
            tgt = TGT_WIDE;
        end else if (row >= DB_ROW0 && row < DB_ROWEND && addr[3:2] == 2'b00) begin
            tgt = TGT_DBELL;
        end
    end

endmodule

// File: rtl/wrc_collector.sv
// Dword collector: stages the lower LANES-1 dwords of a wide write and
// releases the full word when the top lane arrives for the same tag.
// Assumes one write per cycle. The commit outputs are combinational, so the
// caller updates its storage on the same edge as the final write.
module wrc_collector #(
    parameter int LANES = 4,
    parameter int TAG_W = 4,
    parameter int LN_W  = $clog2(LANES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [LN_W-1:0]       lane,
    input  logic [TAG_W-1:0]      tag,
    input  logic [31:0]           wdata,
    output logic                  commit,
    output logic                  mismatch,
    output logic [LANES*32-1:0]   commit_data
);
    localparam logic [LN_W-1:0] LAST = LN_W'(LANES - 1);

    logic                      pend_q;
    logic [TAG_W-1:0]          tag_q;
    logic [(LANES-1)*32-1:0]   stage_q;
    logic                      last_wr;

    assign last_wr     = wr_en && (lane == LAST);
    assign commit      = last_wr && pend_q && (tag == tag_q);
    assign mismatch    = last_wr && !commit;
    assign commit_data = {wdata, stage_q};

    // Track whether a sequence is open and which slot opened it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            tag_q  <= '0;
        end else if (last_wr) begin
            pend_q <= 1'b0;
        end else if (wr_en && !pend_q) begin
            pend_q <= 1'b1;
            tag_q  <= tag;
        end
    end

    // One staging register per lower lane.
    for (genvar g = 0; g < LANES - 1; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[g*32 +: 32] <= '0;
            else if (wr_en && lane == LN_W'(g))
                stage_q[g*32 +: 32] <= wdata;
        end
    end

endmodule

// File: rtl/wide_reg_collector.sv
// Top of the wide register collector. Serves a 32-bit host port in front of
// 128-bit control registers, a 64-bit entry store and per-page doorbells.
// Wide and entry writes commit atomically on the final dword. A dword-0 read
// snapshots the full value for the following dwords.
// Assumes: NUM_PAGES, NUM_WIDE and SRAM_DEPTH are powers of two, NUM_WIDE >= 2,
// ADDR_W = 13 + log2(NUM_PAGES) + 1, and one request per cycle.
module wide_reg_collector
    import wrc_pkg::*;
#(
    parameter int NUM_PAGES  = 4,
    parameter int NUM_WIDE   = 4,
    parameter int SRAM_DEPTH = 16,
    parameter int ADDR_W     = 16,
    parameter int PG_W       = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    output logic              req_rdy,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_vld,
    output logic [31:0]       rsp_data,
    output logic              db_stb,
    output logic [PG_W-1:0]   db_page,
    output logic [1:0]        db_sel,
    output logic [31:0]       db_val,
    output logic              seq_err
);
    localparam int SL_W   = $clog2(NUM_WIDE);
    localparam int SR_W   = $clog2(SRAM_DEPTH);
    localparam int RI_W   = PG_W + SL_W;
    localparam int NREG   = NUM_PAGES * NUM_WIDE;
    localparam int WIDE_W = WIDE_LANES * DWORD_W;
    localparam int SRAM_W = SRAM_LANES * DWORD_W;

    wrc_tgt_e           tgt;
    logic [PG_W-1:0]    page;
    logic [SL_W-1:0]    slot;
    logic [1:0]         lane;
    logic [SR_W-1:0]    sidx;
    logic [1:0]         dsel;
    logic [RI_W-1:0]    ridx;
    logic               acc_wr, acc_rd;

    logic               wide_commit, wide_mis;
    logic [WIDE_W-1:0]  wide_cdata;
    logic               sram_commit, sram_mis;
    logic [SRAM_W-1:0]  sram_cdata;

    logic [WIDE_W-1:0]  wide_q [NREG];
    logic [SRAM_W-1:0]  sram_q [SRAM_DEPTH];
    logic [31:0]        db_q   [NUM_PAGES][DB_PER_PG];
    logic [WIDE_W-1:0]  shadow_q;
    logic [31:0]        sram_hi_q;
    logic [31:0]        rd_mux;
    logic               err_q;

    assign req_rdy = 1'b1;
    assign acc_wr  = req_vld && req_we;
    assign acc_rd  = req_vld && !req_we;
    assign ridx    = {page, slot};
    assign seq_err = err_q;

    wrc_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_WIDE   (NUM_WIDE),
        .SRAM_DEPTH (SRAM_DEPTH),
        .PG_W       (PG_W),
        .SL_W       (SL_W),
        .SR_W       (SR_W)
    ) i_decode (
        .addr     (req_addr),
        .tgt      (tgt),
        .page     (page),
        .slot     (slot),
        .lane     (lane),
        .sram_idx (sidx),
        .db_sel   (dsel)
    );

    wrc_collector #(
        .LANES (WIDE_LANES),
        .TAG_W (RI_W)
    ) i_wide_coll (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (acc_wr && tgt == TGT_WIDE),
        .lane        (lane),
        .tag         (ridx),
        .wdata       (req_wdata),
        .commit      (wide_commit),
        .mismatch    (wide_mis),
        .commit_data (wide_cdata)
    );

    wrc_collector #(
        .LANES (SRAM_LANES),
        .TAG_W (SR_W)
    ) i_sram_coll (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (acc_wr && tgt == TGT_SRAM),
        .lane        (lane[0]),
        .tag         (sidx),
        .wdata       (req_wdata),
        .commit      (sram_commit),
        .mismatch    (sram_mis),
        .commit_data (sram_cdata)
    );

    // Wide register bank: the whole word changes on a matched final dword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) wide_q[i] <= '0;
        end else if (wide_commit) begin
            wide_q[ridx] <= wide_cdata;
        end
    end

    // Entry store: the whole entry changes on a matched high-half write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SRAM_DEPTH; i++) sram_q[i] <= '0;
        end else if (sram_commit) begin
            sram_q[sidx] <= sram_cdata;
        end
    end

    // Doorbells: single-dword writes that take effect at once, plus a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PAGES; p++)
                for (int k = 0; k < DB_PER_PG; k++) db_q[p][k] <= '0;
            db_stb  <= 1'b0;
            db_page <= '0;
            db_sel  <= '0;
            db_val  <= '0;
        end else begin
            db_stb <= acc_wr && tgt == TGT_DBELL;
            if (acc_wr && tgt == TGT_DBELL) begin
                db_q[page][dsel] <= req_wdata;
                db_page          <= page;
                db_sel           <= dsel;
                db_val           <= req_wdata;
            end
        end
    end

    // Sticky error for any dropped commit.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | wide_mis | sram_mis;
    end

    // Read data selection: live low dword or snapshot for upper dwords.
    always_comb begin
        rd_mux = '0;
        case (tgt)
            TGT_WIDE:  rd_mux = (lane == 2'd0) ? wide_q[ridx][31:0]
                                               : shadow_q[{lane, 5'b0} +: 32];
            TGT_DBELL: rd_mux = db_q[page][dsel];
            TGT_SRAM:  rd_mux = lane[0] ? sram_hi_q : sram_q[sidx][31:0];
            default:   rd_mux = '0;
        endcase
    end

    // Snapshots taken on low-dword reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q  <= '0;
            sram_hi_q <= '0;
        end else if (acc_rd) begin
            if (tgt == TGT_WIDE && lane == 2'd0) shadow_q  <= wide_q[ridx];
            if (tgt == TGT_SRAM && !lane[0])     sram_hi_q <= sram_q[sidx][63:32];
        end
    end

    // Read response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_vld  <= acc_rd;
            rsp_data <= acc_rd ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/wrc_checker.sv
// Protocol checker for wide_reg_collector, attached by bind.
// Watches the host port, the doorbell strobe, the error flag and the
// collectors' commit signals.
module wrc_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic              req_rdy,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_vld,
    input logic              db_stb,
    input logic              seq_err,
    input logic              wide_commit,
    input logic              sram_commit
);
    logic unused_addr;
    assign unused_addr = ^req_addr;

    // R3: a wide commit only happens on a write to the top dword
    a_r3_commit_on_top_dword: assert property (@(posedge clk) disable iff (!rst_n)
        wide_commit |-> (req_vld && req_we && req_addr[3:2] == 2'b11));

    // R8: an entry commit only happens on a high-half write into the store
    a_r8_entry_commit_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        sram_commit |-> (req_vld && req_we && req_addr[2] && req_addr[ADDR_W-1]));

    // R10: an accepted read gets its response on the next cycle
    a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_rdy && !req_we) |=> rsp_vld);

    // R10: no response without a read
    a_r10_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_vld && req_rdy && !req_we) |=> !rsp_vld);

    // R11: the error flag holds until reset
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    // R4: the error flag rises only after a write
    a_r4_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $past(req_vld && req_we));

    // R7: the doorbell strobe follows a write
    a_r7_strobe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        db_stb |-> $past(req_vld && req_we));

    // R11: outputs are quiet just after reset
    a_r11_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!seq_err && !rsp_vld && !db_stb));

endmodule

bind wide_reg_collector wrc_checker #(.ADDR_W(ADDR_W)) i_wrc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_vld     (req_vld),
    .req_rdy     (req_rdy),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .rsp_vld     (rsp_vld),
    .db_stb      (db_stb),
    .seq_err     (seq_err),
    .wide_commit (wide_commit),
    .sram_commit (sram_commit)
);

// File: tb/test_wide_reg_collector.sv
// Bench: a behavioural reference model updated on every rising edge and
// compared with the design on every falling edge, plus directed reads.
module test_wide_reg_collector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic        req_rdy;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_vld;
    logic [31:0] rsp_data;
    logic        db_stb;
    logic [1:0]  db_page;
    logic [1:0]  db_sel;
    logic [31:0] db_val;
    logic        seq_err;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string phase = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    wide_reg_collector i_wide_reg_collector (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_rdy(req_rdy),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_vld(rsp_vld), .rsp_data(rsp_data), .db_stb(db_stb),
        .db_page(db_page), .db_sel(db_sel), .db_val(db_val), .seq_err(seq_err)
    );

    // ---------------- reference model ----------------
    logic [127:0] m_wide [16];
    logic [127:0] m_shadow;
    logic [31:0]  m_stage [3];
    bit           m_pend;
    int           m_tag;
    logic [63:0]  m_sram [16];
    logic [31:0]  m_slo;
    bit           m_spend;
    int           m_stag;
    logic [31:0]  m_shi;
    logic [31:0]  m_db [4][3];
    bit           m_err;
    bit           e_rsp_vld, e_db_stb;
    logic [31:0]  e_rsp_data, e_db_val;
    int           e_db_page, e_db_sel;

    always @(posedge clk) begin
        int a, pg, off, sl, ln, idx, k;
        e_rsp_vld = 0;
        e_db_stb  = 0;
        if (!rst_n) begin
            foreach (m_wide[i]) m_wide[i] = '0;
            foreach (m_sram[i]) m_sram[i] = '0;
            for (int p = 0; p < 4; p++) for (int j = 0; j < 3; j++) m_db[p][j] = '0;
            m_shadow = '0; m_pend = 0; m_tag = 0; m_spend = 0; m_stag = 0;
            m_shi = '0; m_slo = '0; m_err = 0; e_rsp_data = '0;
            for (int j = 0; j < 3; j++) m_stage[j] = '0;
        end else if (req_vld) begin
            a = int'(req_addr);
            e_rsp_data = '0;
            if (a >= 'h8000) begin
                idx = (a - 'h8000) / 8;
                ln  = (a % 8) / 4;
                if (idx < 16) begin
                    if (req_we && ln == 0) begin
                        if (!m_spend) begin m_spend = 1; m_stag = idx; end
                        m_slo = req_wdata;
                    end else if (req_we) begin
                        if (m_spend && m_stag == idx) m_sram[idx] = {req_wdata, m_slo};
                        else m_err = 1;
                        m_spend = 0;
                    end else if (ln == 0) begin
                        e_rsp_data = m_sram[idx][31:0];
                        m_shi = m_sram[idx][63:32];
                    end else e_rsp_data = m_shi;
                end
            end else begin
                pg  = a / 'h2000;
                off = a % 'h2000;
                if (off < 4 * 16) begin
                    sl  = off / 16;
                    ln  = (off % 16) / 4;
                    idx = pg * 4 + sl;
                    if (req_we && ln < 3) begin
                        if (!m_pend) begin m_pend = 1; m_tag = idx; end
                        m_stage[ln] = req_wdata;
                    end else if (req_we) begin
                        if (m_pend && m_tag == idx)
                            m_wide[idx] = {req_wdata, m_stage[2], m_stage[1], m_stage[0]};
                        else m_err = 1;
                        m_pend = 0;
                    end else if (ln == 0) begin
                        e_rsp_data = m_wide[idx][31:0];
                        m_shadow = m_wide[idx];
                    end else e_rsp_data = m_shadow[32*ln +: 32];
                end else if (off >= 'h1000 && off < 'h1030 && (off % 16) < 4) begin
                    k = (off - 'h1000) / 16;
                    if (req_we) begin
                        m_db[pg][k] = req_wdata;
                        e_db_stb = 1; e_db_page = pg; e_db_sel = k; e_db_val = req_wdata;
                    end else e_rsp_data = m_db[pg][k];
                end
            end
            e_rsp_vld = !req_we;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h at %0t", phase, what, act, exp, $time);
        end
    endtask

    // Compare the design with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("rsp_vld", 32'(rsp_vld), 32'(e_rsp_vld));
            if (e_rsp_vld) chk("rsp_data", rsp_data, e_rsp_data);
            chk("seq_err", 32'(seq_err), 32'(m_err));
            chk("req_rdy", 32'(req_rdy), 32'd1);
            chk("db_stb", 32'(db_stb), 32'(e_db_stb));
            if (e_db_stb) begin
                chk("db_page", 32'(db_page), 32'(e_db_page));
                chk("db_sel", 32'(db_sel), 32'(e_db_sel));
                chk("db_val", db_val, e_db_val);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(int addr, logic [31:0] d);
        req_vld = 1; req_we = 1; req_addr = 16'(addr); req_wdata = d;
        @(negedge clk);
        req_vld = 0; req_we = 0;
    endtask

    task automatic rd(int addr, logic [31:0] exp);
        req_vld = 1; req_we = 0; req_addr = 16'(addr);
        @(negedge clk);
        req_vld = 0;
        chk($sformatf("read %h", addr), rsp_data, exp);
    endtask

    task automatic wr4(int base, logic [31:0] seed);
        for (int k = 0; k < 4; k++) wr(base + 4 * k, seed + 32'(k));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11: state after reset
        phase = "R11";
        rd('h0000, 0);
        rd('h0004, 0);   // R6: shadow is zero after reset
        chk("err after reset", 32'(seq_err), 0);
        // R1 / R3: full write and read back
        phase = "R1_R3";
        wr4('h0010, 32'hA000_0000);
        rd('h0010, 32'hA000_0000);
        rd('h0014, 32'hA000_0001);
        rd('h0018, 32'hA000_0002);
        rd('h001E, 32'hA000_0003);   // low address bits ignored
        // R2: staged dwords are invisible until the top dword
        phase = "R2";
        wr('h0010, 32'hB000_0000);
        wr('h0014, 32'hB000_0001);
        wr('h0018, 32'hB000_0002);
        rd('h0010, 32'hA000_0000);
        wr('h001C, 32'hB000_0003);
        phase = "R3";
        rd('h0010, 32'hB000_0000);
        // R5: upper dwords come from the snapshot
        phase = "R5";
        wr4('h0010, 32'hC000_0000);
        rd('h0014, 32'hB000_0001);
        rd('h0018, 32'hB000_0002);
        rd('h0010, 32'hC000_0000);
        rd('h001C, 32'hC000_0003);
        // R6: upper read of an unsnapshotted slot is stale
        phase = "R6";
        rd('h2028, 32'hC000_0002);
        // R7: doorbells, including one in the middle of a staged sequence
        phase = "R7";
        wr('h0000, 32'hD000_0000);
        wr('h0004, 32'hD000_0001);
        wr('h1010, 32'h0000_1234);
        wr('h7020, 32'h0000_5678);
        wr('h0008, 32'hD000_0002);
        wr('h000C, 32'hD000_0003);
        rd('h0000, 32'hD000_0000);
        rd('h0004, 32'hD000_0001);
        rd('h1010, 32'h0000_1234);
        rd('h7020, 32'h0000_5678);
        rd('h1000, 0);
        // R8: entry store
        phase = "R8";
        wr('h8028, 32'h1111_2222);
        wr('h802C, 32'h3333_4444);
        wr('h8030, 32'h5555_6666);
        rd('h8030, 0);
        wr('h8034, 32'h7777_8888);
        rd('h8028, 32'h1111_2222);
        rd('h802C, 32'h3333_4444);
        rd('h8030, 32'h5555_6666);
        rd('h8034, 32'h7777_8888);
        // R9: pages are separate
        phase = "R9";
        wr4('h4010, 32'hE000_0000);
        rd('h0010, 32'hC000_0000);
        rd('h4010, 32'hE000_0000);
        rd('h5010, 0);
        // R10: unmapped addresses and back-to-back reads
        phase = "R10";
        wr('h0800, 32'hFFFF_FFFF);
        rd('h0800, 0);
        rd('h1030, 0);
        rd('h1014, 0);
        // R4: mismatched commits
        phase = "R4";
        wr('h0020, 32'h9000_0000);
        wr('h0034, 32'h9000_0001);
        wr('h003C, 32'h9000_0003);
        chk("err after mismatch", 32'(seq_err), 1);
        rd('h0030, 0);
        rd('h0020, 0);
        wr('h002C, 32'h9000_0013);   // nothing staged now
        rd('h0020, 0);
        wr('h8040, 32'h1);
        wr('h804C, 32'h2);
        rd('h8040, 0);
        // R11: error stays set, reset clears everything
        phase = "R11";
        repeat (3) @(negedge clk);
        chk("err sticky", 32'(seq_err), 1);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        chk("err cleared", 32'(seq_err), 0);
        rd('h0010, 0);
        rd('h0014, 0);
        rd('h1010, 0);
        rd('h8028, 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule